// File: doc/BRIEF.md
# Serial EEPROM Page-Write Controller

This block is the write half of a two-wire serial EEPROM slave, working one byte at a time. A bit-level front end passes it decoded start and stop events, each completed byte with a one-cycle valid strobe, and a flag that says a byte is still only partly received. It also passes a request that marks the acknowledge slot. The controller answers each slot with a drive-acknowledge output. It checks the device select byte, takes the word address, and gathers up to sixteen data bytes in a one-page latch.

A stop ends the transaction. If at least one byte was latched, a timed internal write cycle starts. At the end of that cycle only the written locations of the page are copied into the storage array. While the cycle runs the controller ignores the bus and never acknowledges, so a master can poll with repeated select codes until it receives an acknowledge. Each page has its own protect bit, supplied from a configuration input. A plain combinational read port into the array lets the neighbouring read logic see the stored data.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After a start, a received byte whose bits [7:1] equal SEL_ADDR (default 7'h50) and whose bit 0 (direction) is 0 is acknowledged. Any other first byte, including one with bit 0 = 1, gets NoAck, and every later byte up to the next start also gets NoAck.
- R2: The byte that follows an acknowledged select byte is acknowledged and becomes the word address (bits [ADDR_W-1:0]).
- R3: Each data byte sent to an unprotected page is acknowledged and latched at the current address. The address then advances by one.
- R4: The address advance keeps the page bits (address bits above PAGE_W) fixed and wraps the low PAGE_W bits. Bytes past the end of the page therefore overwrite earlier bytes of the same transaction, and the last value written to an offset wins.
- R5: Bit i of wp_pages protects addresses i*16 to i*16+15. A data byte sent to a protected page gets NoAck and leaves the array unchanged.
- R6: A stop with no partial byte, after at least one latched data byte, sets busy on the next cycle. Busy stays high for exactly WR_CYCLES cycles.
- R7: When busy falls, the latched bytes appear in the array at their addresses. Offsets of the page that were not written keep their old contents, and the array does not change at any other time.
- R8: While busy is high the bus is ignored. A start followed by a matching select byte gets NoAck.
- R9: Once busy has fallen, a start followed by a matching select byte is acknowledged.
- R10: A stop that arrives while byte_open is high, or a stop with no latched data byte, starts no write cycle and leaves the array unchanged.
- R11: After reset, busy is 0, ack_drive is 0 and every array byte reads 8'hFF.
- R12: ack_drive is high only while ack_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_evt | input | 1 | One-cycle pulse: start condition seen |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen |
| byte_open | input | 1 | Front end holds part of an unfinished byte |
| rx_valid | input | 1 | One-cycle pulse: rx_byte holds a completed byte |
| rx_byte | input | 8 | Received byte |
| ack_req | input | 1 | Acknowledge slot in progress |
| wp_pages | input | 2**(ADDR_W-PAGE_W) | Protect bit per page |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data |
| ack_drive | output | 1 | Pull the data line low for acknowledge |
| busy | output | 1 | Internal write cycle running |

## Verification
The bench goes after the page wrap. A controller that carried the address into the next page would leave the target page's first bytes holding stale data and would corrupt the neighbouring page. It also checks partial-page writes, where a design that committed the whole latch would wipe unwritten neighbours with old latch contents. Polling during the write cycle, an exact busy length, protected pages and aborted stops are all covered: a wrong design would acknowledge too early, report the wrong cycle length, or modify memory that should stay untouched.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEL  = 2'd1,
        PH_ADDR = 2'd2,
        PH_DATA = 2'd3
    } phase_e;
endpackage

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
    parameter int WR_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        done  = 1'b0;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == CW'(1)) done = 1'b1;
        end else if (go) begin
            cnt_d = CW'(WR_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/eeprom_wr_latch.sv
module eeprom_wr_latch #(
    parameter int PAGE_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr,
    input  logic [PAGE_W-1:0]      wr_off,
    input  logic [7:0]             wr_byte,
    output logic [(8<<PAGE_W)-1:0] data,
    output logic [(1<<PAGE_W)-1:0] mask
);
    localparam int PB = 1 << PAGE_W;

    logic [PB*8-1:0] data_d, data_q;
    logic [PB-1:0]   mask_d, mask_q;

    always_comb begin
        data_d = data_q;
        mask_d = mask_q;
        if (clr) begin
            mask_d = '0;
        end else if (wr) begin
            data_d[int'(wr_off)*8 +: 8] = wr_byte;
            mask_d[wr_off]              = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
        end else begin
            data_q <= data_d;
            mask_q <= mask_d;
        end
    end

    assign data = data_q;
    assign mask = mask_q;
endmodule

// File: rtl/eeprom_wr_array.sv
module eeprom_wr_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [ADDR_W-PAGE_W-1:0]    page,
    input  logic [(8<<PAGE_W)-1:0]      data,
    input  logic [(1<<PAGE_W)-1:0]      mask,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [7:0]                  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PB    = 1 << PAGE_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            for (int o = 0; o < PB; o++) begin
                if (mask[o]) mem_d[{page, PAGE_W'(o)}] = data[o*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl #(
    parameter int         ADDR_W    = 8,
    parameter int         PAGE_W    = 4,
    parameter int         WR_CYCLES = 40,
    parameter logic [6:0] SEL_ADDR  = 7'h50
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_evt,
    input  logic                            stop_evt,
    input  logic                            byte_open,
    input  logic                            rx_valid,
    input  logic [7:0]                      rx_byte,
    input  logic                            ack_req,
    input  logic [(1<<(ADDR_W-PAGE_W))-1:0] wp_pages,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [7:0]                      rd_data,
    output logic                            ack_drive,
    output logic                            busy
);
    import eeprom_wr_pkg::*;

    localparam int PG_W = ADDR_W - PAGE_W;
    localparam int PB   = 1 << PAGE_W;

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic              ack_ok;
        logic [PG_W-1:0]   cpage;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              lat_clr, lat_wr, wr_go, wr_done;
    logic [PB*8-1:0]   lat_data;
    logic [PB-1:0]     lat_mask;
    logic [PG_W-1:0]   cur_page;

    assign cur_page = ctl_q.addr[ADDR_W-1:PAGE_W];

    always_comb begin
        ctl_d   = ctl_q;
        lat_clr = 1'b0;
        lat_wr  = 1'b0;
        wr_go   = 1'b0;
        if (busy) begin
            ctl_d.ph     = PH_IDLE;
            ctl_d.ack_ok = 1'b0;
        end else if (stop_evt) begin
            ctl_d.ph     = PH_IDLE;
            ctl_d.ack_ok = 1'b0;
            if (ctl_q.ph == PH_DATA && !byte_open && (lat_mask != '0)) begin
                wr_go       = 1'b1;
                ctl_d.cpage = cur_page;
            end
        end else if (start_evt) begin
            ctl_d.ph     = PH_SEL;
            ctl_d.ack_ok = 1'b0;
            lat_clr      = 1'b1;
        end else if (rx_valid) begin
            case (ctl_q.ph)
                PH_SEL: begin
                    if (rx_byte[7:1] == SEL_ADDR && !rx_byte[0]) begin
                        ctl_d.ph     = PH_ADDR;
                        ctl_d.ack_ok = 1'b1;
                    end else begin
                        ctl_d.ph     = PH_IDLE;
                        ctl_d.ack_ok = 1'b0;
                    end
                end
                PH_ADDR: begin
                    ctl_d.addr   = rx_byte[ADDR_W-1:0];
                    ctl_d.ph     = PH_DATA;
                    ctl_d.ack_ok = 1'b1;
                end
                PH_DATA: begin
                    if (wp_pages[cur_page]) begin
                        ctl_d.ack_ok = 1'b0;
                    end else begin
                        lat_wr       = 1'b1;
                        ctl_d.ack_ok = 1'b1;
                    end
                    ctl_d.addr = {cur_page, ctl_q.addr[PAGE_W-1:0] + 1'b1};
                end
                default: ctl_d.ack_ok = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.ph     <= PH_IDLE;
            ctl_q.addr   <= '0;
            ctl_q.ack_ok <= 1'b0;
            ctl_q.cpage  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    eeprom_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (wr_go),
        .busy  (busy),
        .done  (wr_done)
    );

    eeprom_wr_latch #(.PAGE_W(PAGE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (lat_clr),
        .wr      (lat_wr),
        .wr_off  (ctl_q.addr[PAGE_W-1:0]),
        .wr_byte (rx_byte),
        .data    (lat_data),
        .mask    (lat_mask)
    );

    eeprom_wr_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (wr_done),
        .page    (ctl_q.cpage),
        .data    (lat_data),
        .mask    (lat_mask),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign ack_drive = ack_req & ctl_q.ack_ok & ~busy;
endmodule

// File: rtl/eeprom_wr_ctrl_chk.sv
module eeprom_wr_ctrl_chk #(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_evt,
    input logic              byte_open,
    input logic              ack_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              ack_drive,
    input logic              busy
);
    localparam int RW = $clog2(WR_CYCLES + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    p_poll_noack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack_drive);

    p_ack_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> ack_req);

    p_busy_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RW'(WR_CYCLES)));

    p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(busy) && $stable(rd_addr)) |-> $stable(rd_data));

    p_open_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && byte_open && !busy) |=> !busy);
endmodule

bind eeprom_wr_ctrl eeprom_wr_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .WR_CYCLES (WR_CYCLES)
) u_chk (.*);

// File: tb/eeprom_wr_ctrl_tb.sv
module eeprom_wr_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_WRC     = 12;
    localparam logic [7:0] SEL_W = 8'hA0;

    // table entry: {start address, byte count, first data value}
    localparam int NV = 5;
    localparam logic [20:0] VEC [NV] = '{
        {8'h23, 5'd1,  8'hA0},
        {8'h40, 5'd16, 8'h10},
        {8'h5C, 5'd8,  8'h30},
        {8'h70, 5'd18, 8'h60},
        {8'h25, 5'd3,  8'hC0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_evt = 1'b0, stop_evt = 1'b0, byte_open = 1'b0;
    logic        rx_valid = 1'b0, ack_req = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [15:0] wp_pages = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        ack_drive, busy;

    int n_chk = 0, n_bad = 0;
    logic [7:0] model [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_wr_ctrl #(.WR_CYCLES(TB_WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_open(byte_open), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack_req(ack_req), .wp_pages(wp_pages), .rd_addr(rd_addr),
        .rd_data(rd_data), .ack_drive(ack_drive), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic do_stop(input logic open);
        @(negedge clk); stop_evt = 1'b1; byte_open = open;
        @(negedge clk); stop_evt = 1'b0; byte_open = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0; ack_req = 1'b1;
        #1 chk(tag, ack_drive, exp_ack);
        @(negedge clk); ack_req = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
        @(negedge clk);
    endtask

    task automatic check_mem(input logic [7:0] a, input string tag);
        @(negedge clk); rd_addr = a;
        #1 chk(tag, rd_data, model[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state, R12 gating
        ack_req = 1'b1;
        #1 chk("R11 busy", busy, 0);
        chk("R11 ack", ack_drive, 0);
        ack_req = 1'b0;
        check_mem(8'h00, "R11 mem");
        check_mem(8'hFF, "R11 mem");

        // table: page writes, R2 R3 R4 R7
        for (int v = 0; v < NV; v++) begin
            logic [7:0] a0 = VEC[v][20:13];
            int         cnt = int'(VEC[v][12:8]);
            logic [7:0] sd = VEC[v][7:0];
            do_start();
            send(SEL_W, 1'b1, "R1 select");
            send(a0, 1'b1, "R2 address");
            for (int k = 0; k < cnt; k++) begin
                logic [7:0] ad = {a0[7:4], 4'(a0[3:0] + k)};
                model[ad] = sd + 8'(k);
                send(sd + 8'(k), 1'b1, "R3 data ack");
            end
            do_stop(1'b0);
            wait_idle();
            for (int o = 0; o < 16; o++)
                check_mem({a0[7:4], 4'(o)}, "R4 R7 page contents");
        end

        // R1 mismatched select and read direction
        do_start();
        send(8'hA2, 1'b0, "R1 bad select");
        send(8'h10, 1'b0, "R1 ignored addr");
        send(8'h99, 1'b0, "R1 ignored data");
        do_stop(1'b0);
        #1 chk("R1 no cycle", busy, 0);
        check_mem(8'h10, "R1 mem untouched");
        do_start();
        send(8'hA1, 1'b0, "R1 read direction");
        do_stop(1'b0);

        // R5 protected page 3
        wp_pages = 16'h0008;
        do_start();
        send(SEL_W, 1'b1, "R5 select");
        send(8'h31, 1'b1, "R5 address");
        send(8'h55, 1'b0, "R5 protected data");
        send(8'h56, 1'b0, "R5 protected data");
        do_stop(1'b0);
        #1 chk("R5 no cycle", busy, 0);
        check_mem(8'h31, "R5 mem untouched");
        check_mem(8'h32, "R5 mem untouched");
        wp_pages = '0;

        // R6 exact busy length
        do_start();
        send(SEL_W, 1'b1, "R6 select");
        send(8'h90, 1'b1, "R6 address");
        model[8'h90] = 8'h11;
        send(8'h11, 1'b1, "R6 data");
        begin
            int n = 0;
            do_stop(1'b0);
            while (busy && n < 1000) begin n++; @(negedge clk); end
            chk("R6 busy length", n, TB_WRC);
        end
        check_mem(8'h90, "R7 committed");

        // R8 polling during cycle, R9 ack afterwards
        do_start();
        send(SEL_W, 1'b1, "R8 select");
        send(8'h91, 1'b1, "R8 address");
        model[8'h91] = 8'h22;
        send(8'h22, 1'b1, "R8 data");
        do_stop(1'b0);
        do_start();
        send(SEL_W, 1'b0, "R8 poll while busy");
        #1 chk("R8 busy during poll", busy, 1);
        wait_idle();
        do_start();
        send(SEL_W, 1'b1, "R9 poll after cycle");
        // R12 gating: ack_ok held, ack_req low
        @(negedge clk); #1 chk("R12 no req", ack_drive, 0);
        do_stop(1'b0);
        #1 chk("R10 no data no cycle", busy, 0);
        check_mem(8'h91, "R7 second commit");

        // R10 stop during partial byte
        do_start();
        send(SEL_W, 1'b1, "R10 select");
        send(8'hB0, 1'b1, "R10 address");
        send(8'h77, 1'b1, "R10 data");
        do_stop(1'b1);
        #1 chk("R10 aborted stop", busy, 0);
        repeat (TB_WRC + 2) @(negedge clk);
        check_mem(8'hB0, "R10 mem untouched");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule